// File: doc/BRIEF.md
# Secondary Interrupt Stage with Edge Control

This block collects interrupt events from up to `NUM_SRC` asynchronous source wires and reports them to a primary aggregator over two host request lines. Each source passes through a two-flop synchroniser. A per-source two-bit edge code then selects rising, falling, both or no edges. An event is recorded in a status register that belongs to each line. Each line also has its own mask register, and the edge configuration is shared by both lines. A line's request output is high while any of its status bits is set and not masked.

Software reaches the block through a byte-wide register port. The control byte chooses how status is cleared: either reading a status byte clears the bits it returned, or software writes ones to the bits it wants cleared. The control byte also chooses whether a second event on a source is held back while the first is still pending. When it is held, the status bit comes back at once after it is cleared, so the second event is not lost.

Top module: `sec_irq_unit`

## Requirements
- R1: Each source is sampled by two flip-flops before edge detection, so a level change driven before clock edge A sets status at edge C, two edges after A, and the request rises in the cycle after edge C.
- R2: Source i owns edge-register byte i/4, bits (i mod 4)*2+1 and (i mod 4)*2. The upper bit enables rising edges and the lower bit enables falling edges; both may be set.
- R3: A source whose edge code is 00 never sets any status bit. After reset every edge code is 00.
- R4: The two lines have independent status and mask registers. An event sets the source's status bit in both lines, and clearing or masking one line leaves the other unchanged.
- R5: A mask bit of 1 blocks that source from the line's request but does not stop its status bit from being set. After reset all mask bits are 1.
- R6: A line's request output equals the OR over all sources of (status AND NOT mask) for that line.
- R7: With control bit 0 (clear-on-read) at 1, reading a status byte clears exactly the bits it returned, and writes to status bytes have no effect.
- R8: With control bit 0 at 0, writing a status byte clears the bits written as 1, and reads leave status unchanged.
- R9: With control bit 1 (hold-off) at 0, an event on a source whose status bit is already set is held, and the status bit stays set after the next clear. With control bit 1 at 1, such an event is dropped.
- R10: When a clear and a new event hit the same status bit in the same cycle, the bit stays set.
- R11: Byte addresses for 24 sources: line-0 status 0..2, line-1 status 3..5, line-0 mask 6..8, line-1 mask 9..11, edge 12..17, control 18. Multi-byte registers are little-endian. Read data appears one cycle after the read strobe, and unmapped addresses read 0.
- R12: After reset all status bits, the control byte and both request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_SRC | Asynchronous source levels |
| addr_i | input | ADDR_W | Register byte address |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wr_data_i | input | 8 | Write data byte |
| rd_en_i | input | 1 | Read strobe for one cycle |
| rd_data_o | output | 8 | Read data, registered, valid the cycle after the strobe |
| irq0_o | output | 1 | Request for host line 0 |
| irq1_o | output | 1 | Request for host line 1 |

## Verification
The sources are driven with rising-only, falling-only and both-edge codes at positions in the first, middle and last edge bytes. This separates a correct bit-pair placement from a shifted one and a rising decode from a falling one. Pairs of pulses on one source are run once with hold-off off and once with it on, which separates a buffered second event from a dropped one. Clears are issued once by read and once by write-one, and one clear is timed to land in the same cycle as an edge. Together these distinguish the two clear modes and show which way the clear/event race is resolved. Both lines are checked against each other so that a clear or mask leaking from one line to the other shows up.

// File: rtl/sec_irq_pkg.sv
// Shared sizing helpers and types for the secondary interrupt stage.
// Assumes byte-wide register access and at most 32 sources.
package sec_irq_pkg;

    // Bytes spanned by a one-bit-per-source register.
    function automatic int stat_bytes(input int n);
        return (n + 7) / 8;
    endfunction

    // Bytes spanned by the two-bit-per-source edge register.
    function automatic int edge_bytes(input int n);
        return (2 * n + 7) / 8;
    endfunction

    // Byte address of the control register (last mapped address).
    function automatic int ctrl_addr(input int n);
        return 4 * stat_bytes(n) + edge_bytes(n);
    endfunction

    // Address width needed to reach every mapped byte.
    function automatic int addr_bits(input int n);
        return $clog2(ctrl_addr(n) + 1);
    endfunction

    // Control byte: bit 0 clear-on-read, bit 1 hold-off (no buffering).
    typedef struct packed {
        logic hold_off;
        logic clr_on_rd;
    } ctrl_t;

endpackage

// File: rtl/sec_irq_sync.sv
// Synchronises the source levels with two flops and turns the
// configured edges into one-cycle event pulses.
// Assumes edge_cfg_i holds two bits per source: upper = rising, lower = falling.
module sec_irq_sync #(
    parameter int NUM_SRC = 24
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NUM_SRC-1:0]     src_i,
    input  logic [2*NUM_SRC-1:0]   edge_cfg_i,
    output logic [NUM_SRC-1:0]     event_o
);
    logic [NUM_SRC-1:0] meta_q;
    logic [NUM_SRC-1:0] sync_q;
    logic [NUM_SRC-1:0] prev_q;

    // Two-stage synchroniser followed by one history flop for edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= src_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Per-source edge decode gated by that source's two-bit code.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_edge
        logic rise_seen;
        logic fall_seen;
        assign rise_seen  = sync_q[i] & ~prev_q[i];
        assign fall_seen  = ~sync_q[i] & prev_q[i];
        assign event_o[i] = (edge_cfg_i[2*i+1] & rise_seen) |
                            (edge_cfg_i[2*i]   & fall_seen);
    end

endmodule

// File: rtl/sec_irq_line.sv
// Status and hold-over state for one host line, plus its request output.
// Assumes clr_i and event_i are one-cycle pulses from the register file
// and the edge decoder; mask_i is the line's mask (1 = blocked).
module sec_irq_line #(
    parameter int NUM_SRC = 24
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] event_i,
    input  logic [NUM_SRC-1:0] clr_i,
    input  logic               hold_off_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic [NUM_SRC-1:0] stat_o,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] stat_q, stat_d;
    logic [NUM_SRC-1:0] held_q, held_d;

    // Next-state rule per source: a clear lets a new or held event win,
    // a pending bit may hold one more event, an idle bit takes the event.
    always_comb begin
        stat_d = stat_q;
        held_d = held_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (clr_i[i]) begin
                stat_d[i] = event_i[i] | held_q[i];
                held_d[i] = 1'b0;
            end else if (stat_q[i]) begin
                if (event_i[i] && !hold_off_i) begin
                    held_d[i] = 1'b1;
                end
            end else begin
                stat_d[i] = event_i[i];
            end
        end
    end

    // State registers for status and the one-deep hold-over.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            stat_q <= '0;
            held_q <= '0;
        end else begin
            stat_q <= stat_d;
            held_q <= held_d;
        end
    end

    assign stat_o = stat_q;
    assign irq_o  = |(stat_q & ~mask_i);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        AST_SET_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!stat_q[i] && !event_i[i]) |=> !stat_q[i]); // R3
        AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stat_q[i] && !clr_i[i]) |=> stat_q[i]); // R8
        AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i[i] && event_i[i]) |=> stat_q[i]); // R10
    end

endmodule

// File: rtl/sec_irq_regs.sv
// Byte-wide register file: masks, shared edge codes, control byte,
// registered read data and the clear pulses for both status sets.
// Assumes one access per strobe; read and write may share a cycle.
module sec_irq_regs
    import sec_irq_pkg::*;
#(
    parameter int NUM_SRC = 24,
    parameter int AW      = 5
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [AW-1:0]        addr_i,
    input  logic                 wr_en_i,
    input  logic [7:0]           wr_data_i,
    input  logic                 rd_en_i,
    input  logic [NUM_SRC-1:0]   stat0_i,
    input  logic [NUM_SRC-1:0]   stat1_i,
    output logic [NUM_SRC-1:0]   mask0_o,
    output logic [NUM_SRC-1:0]   mask1_o,
    output logic [2*NUM_SRC-1:0] edge_o,
    output ctrl_t                ctrl_o,
    output logic [NUM_SRC-1:0]   clr0_o,
    output logic [NUM_SRC-1:0]   clr1_o,
    output logic [7:0]           rd_data_o
);
    localparam int SB      = stat_bytes(NUM_SRC);
    localparam int EB      = edge_bytes(NUM_SRC);
    localparam int S0_BASE = 0;
    localparam int S1_BASE = SB;
    localparam int M0_BASE = 2 * SB;
    localparam int M1_BASE = 3 * SB;
    localparam int ED_BASE = 4 * SB;
    localparam int CT_ADDR = ctrl_addr(NUM_SRC);

    logic [SB*8-1:0] mask0_q, mask1_q;
    logic [EB*8-1:0] edge_q;
    ctrl_t           ctrl_q;
    logic [SB*8-1:0] stat0_pad, stat1_pad;
    logic [SB*8-1:0] clr0_pad, clr1_pad;
    logic [7:0]      rd_byte;
    logic [7:0]      rd_q;

    // Widen status vectors to whole bytes for byte selection.
    always_comb begin
        stat0_pad = '0;
        stat1_pad = '0;
        stat0_pad[NUM_SRC-1:0] = stat0_i;
        stat1_pad[NUM_SRC-1:0] = stat1_i;
    end

    // Configuration registers written by byte address.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mask0_q <= '1;
            mask1_q <= '1;
            edge_q  <= '0;
            ctrl_q  <= '0;
        end else if (wr_en_i) begin
            for (int b = 0; b < SB; b++) begin
                if (addr_i == AW'(M0_BASE + b)) mask0_q[b*8 +: 8] <= wr_data_i;
                if (addr_i == AW'(M1_BASE + b)) mask1_q[b*8 +: 8] <= wr_data_i;
            end
            for (int b = 0; b < EB; b++) begin
                if (addr_i == AW'(ED_BASE + b)) edge_q[b*8 +: 8] <= wr_data_i;
            end
            if (addr_i == AW'(CT_ADDR)) begin
                ctrl_q <= ctrl_t'(wr_data_i[1:0]);
            end
        end
    end

    // Read multiplexer over every mapped byte; unmapped bytes read zero.
    always_comb begin
        rd_byte = 8'h00;
        for (int b = 0; b < SB; b++) begin
            if (addr_i == AW'(S0_BASE + b)) rd_byte = stat0_pad[b*8 +: 8];
            if (addr_i == AW'(S1_BASE + b)) rd_byte = stat1_pad[b*8 +: 8];
            if (addr_i == AW'(M0_BASE + b)) rd_byte = mask0_q[b*8 +: 8];
            if (addr_i == AW'(M1_BASE + b)) rd_byte = mask1_q[b*8 +: 8];
        end
        for (int b = 0; b < EB; b++) begin
            if (addr_i == AW'(ED_BASE + b)) rd_byte = edge_q[b*8 +: 8];
        end
        if (addr_i == AW'(CT_ADDR)) rd_byte = {6'b0, ctrl_q};
    end

    // Clear pulses: returned bits in clear-on-read mode, written ones otherwise.
    always_comb begin
        clr0_pad = '0;
        clr1_pad = '0;
        for (int b = 0; b < SB; b++) begin
            if (addr_i == AW'(S0_BASE + b)) begin
                if (rd_en_i && ctrl_q.clr_on_rd)  clr0_pad[b*8 +: 8] = stat0_pad[b*8 +: 8];
                if (wr_en_i && !ctrl_q.clr_on_rd) clr0_pad[b*8 +: 8] = clr0_pad[b*8 +: 8] | wr_data_i;
            end
            if (addr_i == AW'(S1_BASE + b)) begin
                if (rd_en_i && ctrl_q.clr_on_rd)  clr1_pad[b*8 +: 8] = stat1_pad[b*8 +: 8];
                if (wr_en_i && !ctrl_q.clr_on_rd) clr1_pad[b*8 +: 8] = clr1_pad[b*8 +: 8] | wr_data_i;
            end
        end
    end

    // Registered read data, zero when no read was strobed.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) rd_q <= 8'h00;
        else         rd_q <= rd_en_i ? rd_byte : 8'h00;
    end

    assign mask0_o   = mask0_q[NUM_SRC-1:0];
    assign mask1_o   = mask1_q[NUM_SRC-1:0];
    assign edge_o    = edge_q[2*NUM_SRC-1:0];
    assign ctrl_o    = ctrl_q;
    assign clr0_o    = clr0_pad[NUM_SRC-1:0];
    assign clr1_o    = clr1_pad[NUM_SRC-1:0];
    assign rd_data_o = rd_q;

    AST_MASK_ALL_SET: assert property (@(posedge clk_i)
        !rst_ni |=> (&mask0_q && &mask1_q)); // R5
    AST_EDGE_OFF_AT_RESET: assert property (@(posedge clk_i)
        !rst_ni |=> (edge_q == '0)); // R3
    AST_IDLE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> (rd_q == 8'h00)); // R11

endmodule

// File: rtl/sec_irq_unit.sv
// Top of the secondary interrupt stage: edge decode, two status/mask
// lines and the register file. Assumes src_i is asynchronous and the
// register port is driven synchronously to clk_i.
module sec_irq_unit
    import sec_irq_pkg::*;
#(
    parameter  int NUM_SRC = 24,
    localparam int ADDR_W  = addr_bits(NUM_SRC)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic [7:0]         wr_data_i,
    input  logic               rd_en_i,
    output logic [7:0]         rd_data_o,
    output logic               irq0_o,
    output logic               irq1_o
);
    logic [NUM_SRC-1:0]   events;
    logic [2*NUM_SRC-1:0] edge_cfg;
    logic [NUM_SRC-1:0]   mask0, mask1;
    logic [NUM_SRC-1:0]   stat0, stat1;
    logic [NUM_SRC-1:0]   clr0, clr1;
    ctrl_t                ctrl;

    sec_irq_sync #(.NUM_SRC(NUM_SRC)) u_sync (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_i      (src_i),
        .edge_cfg_i (edge_cfg),
        .event_o    (events)
    );

    sec_irq_line #(.NUM_SRC(NUM_SRC)) u_line0 (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .event_i    (events),
        .clr_i      (clr0),
        .hold_off_i (ctrl.hold_off),
        .mask_i     (mask0),
        .stat_o     (stat0),
        .irq_o      (irq0_o)
    );

    sec_irq_line #(.NUM_SRC(NUM_SRC)) u_line1 (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .event_i    (events),
        .clr_i      (clr1),
        .hold_off_i (ctrl.hold_off),
        .mask_i     (mask1),
        .stat_o     (stat1),
        .irq_o      (irq1_o)
    );

    sec_irq_regs #(.NUM_SRC(NUM_SRC), .AW(ADDR_W)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_en_i   (rd_en_i),
        .stat0_i   (stat0),
        .stat1_i   (stat1),
        .mask0_o   (mask0),
        .mask1_o   (mask1),
        .edge_o    (edge_cfg),
        .ctrl_o    (ctrl),
        .clr0_o    (clr0),
        .clr1_o    (clr1),
        .rd_data_o (rd_data_o)
    );

    AST_REQ_OFF_AT_RESET: assert property (@(posedge clk_i)
        !rst_ni |=> (!irq0_o && !irq1_o)); // R12
    AST_LINE0_IGNORES_LINE1_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat0 != '0 && clr0 == '0) |=> (stat0 != '0)); // R4

endmodule

// File: tb/tb_sec_irq_unit.sv
// Bench: behavioural reference model compared every clock, plus
// directed checks tagged with requirement numbers.
module tb_sec_irq_unit;
    localparam int N = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        irq0, irq1;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit run_cmp = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sec_irq_unit #(.NUM_SRC(N)) dut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr),
        .wr_en_i(wr_en), .wr_data_i(wdata), .rd_en_i(rd_en),
        .rd_data_o(rd_data), .irq0_o(irq0), .irq1_o(irq1)
    );

    // ---------------- reference model ----------------
    logic [N-1:0]   m1, m2, mp, st0, st1, sh0, sh1, mk0, mk1;
    logic [2*N-1:0] med;
    logic           mcor, mhold;
    logic [7:0]     mrd;
    logic [N-1:0]   t_ev, t_c0, t_c1;
    logic [7:0]     t_rv;
    int             t_a;

    always @(posedge clk) begin
        if (!rst_n) begin
            m1 = '0; m2 = '0; mp = '0; st0 = '0; st1 = '0; sh0 = '0; sh1 = '0;
            mk0 = '1; mk1 = '1; med = '0; mcor = 1'b0; mhold = 1'b0; mrd = 8'h00;
        end else begin
            t_a = int'(addr);
            for (int i = 0; i < N; i++)
                t_ev[i] = (med[2*i+1] && m2[i] && !mp[i]) || (med[2*i] && !m2[i] && mp[i]);
            if (t_a < 3)       t_rv = st0[t_a*8 +: 8];
            else if (t_a < 6)  t_rv = st1[(t_a-3)*8 +: 8];
            else if (t_a < 9)  t_rv = mk0[(t_a-6)*8 +: 8];
            else if (t_a < 12) t_rv = mk1[(t_a-9)*8 +: 8];
            else if (t_a < 18) t_rv = med[(t_a-12)*8 +: 8];
            else if (t_a == 18) t_rv = {6'b0, mhold, mcor};
            else               t_rv = 8'h00;
            t_c0 = '0; t_c1 = '0;
            if (t_a < 3) begin
                if (rd_en && mcor)  t_c0[t_a*8 +: 8] = st0[t_a*8 +: 8];
                if (wr_en && !mcor) t_c0[t_a*8 +: 8] = t_c0[t_a*8 +: 8] | wdata;
            end else if (t_a < 6) begin
                if (rd_en && mcor)  t_c1[(t_a-3)*8 +: 8] = st1[(t_a-3)*8 +: 8];
                if (wr_en && !mcor) t_c1[(t_a-3)*8 +: 8] = t_c1[(t_a-3)*8 +: 8] | wdata;
            end
            for (int i = 0; i < N; i++) begin
                if (t_c0[i]) begin st0[i] = t_ev[i] | sh0[i]; sh0[i] = 1'b0; end
                else if (st0[i]) begin if (t_ev[i] && !mhold) sh0[i] = 1'b1; end
                else st0[i] = t_ev[i];
                if (t_c1[i]) begin st1[i] = t_ev[i] | sh1[i]; sh1[i] = 1'b0; end
                else if (st1[i]) begin if (t_ev[i] && !mhold) sh1[i] = 1'b1; end
                else st1[i] = t_ev[i];
            end
            if (wr_en) begin
                if (t_a >= 6 && t_a < 9)        mk0[(t_a-6)*8 +: 8] = wdata;
                else if (t_a >= 9 && t_a < 12)  mk1[(t_a-9)*8 +: 8] = wdata;
                else if (t_a >= 12 && t_a < 18) med[(t_a-12)*8 +: 8] = wdata;
                else if (t_a == 18) begin mcor = wdata[0]; mhold = wdata[1]; end
            end
            mp = m2; m2 = m1; m1 = src;
            mrd = rd_en ? t_rv : 8'h00;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Every-clock comparison against the model (R6 requests, R11 read data).
    always @(negedge clk) begin
        if (run_cmp && !done) begin
            chk({7'b0, irq0}, {7'b0, |(st0 & ~mk0)}, "R6 irq0 vs model");
            chk({7'b0, irq1}, {7'b0, |(st1 & ~mk1)}, "R6 irq1 vs model");
            chk(rd_data, mrd, "R11 rd_data vs model");
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<50000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        addr = a[4:0]; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [7:0] exp, input string tag);
        addr = a[4:0]; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(rd_data, exp, tag);
    endtask

    task automatic pulse(input int i);
        src[i] = 1'b1; idle(4);
        src[i] = 1'b0; idle(4);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        run_cmp = 1'b1;
        idle(1);
        // Reset state
        chk({7'b0, irq0}, 8'h00, "R12 irq0 after reset");
        chk({7'b0, irq1}, 8'h00, "R12 irq1 after reset");
        rd_chk(6, 8'hFF, "R5 mask0 byte0 reset");
        rd_chk(11, 8'hFF, "R5 mask1 byte2 reset");
        rd_chk(18, 8'h00, "R12 control reset");
        rd_chk(0, 8'h00, "R12 status reset");
        // Disabled edges ignore activity
        pulse(0);
        rd_chk(0, 8'h00, "R3 code 00 no status");
        rd_chk(3, 8'h00, "R3 code 00 no status line1");
        // Rising on source 0, unmasked on line 0 only
        wr(12, 8'h02);
        wr(6, 8'hFE);
        rd_chk(12, 8'h02, "R11 edge readback");
        pulse(0);
        chk({7'b0, irq0}, 8'h01, "R6 irq0 raised");
        chk({7'b0, irq1}, 8'h00, "R5 irq1 masked");
        rd_chk(3, 8'h01, "R5 status set though masked");
        rd_chk(0, 8'h01, "R2 source0 rising");
        wr(0, 8'h01);
        chk({7'b0, irq0}, 8'h00, "R8 irq0 after W1C");
        rd_chk(0, 8'h00, "R8 status cleared");
        rd_chk(3, 8'h01, "R4 line1 untouched");
        wr(3, 8'h01);
        // Falling only on source 5
        wr(13, 8'h04);
        src[5] = 1'b1; idle(5);
        rd_chk(0, 8'h00, "R2 rise ignored for fall code");
        src[5] = 1'b0; idle(5);
        rd_chk(0, 8'h20, "R2 source5 falling");
        wr(0, 8'h20); wr(3, 8'h20);
        // Both edges on source 9
        wr(14, 8'h0C);
        src[9] = 1'b1; idle(5);
        rd_chk(1, 8'h02, "R2 source9 rise");
        wr(1, 8'h02);
        src[9] = 1'b0; idle(5);
        rd_chk(1, 8'h02, "R2 source9 fall");
        wr(1, 8'h02); wr(4, 8'hFF);
        // Rising on source 23, unmasked on line 1 only
        wr(17, 8'h80);
        pulse(23);
        rd_chk(2, 8'h80, "R2 source23 rising");
        wr(11, 8'h7F);
        chk({7'b0, irq1}, 8'h01, "R6 irq1 raised");
        chk({7'b0, irq0}, 8'h00, "R5 irq0 masked src23");
        // Clear-on-read
        wr(18, 8'h01);
        rd_chk(2, 8'h80, "R7 read returns bit");
        rd_chk(2, 8'h00, "R7 read cleared bit");
        chk({7'b0, irq1}, 8'h01, "R4 line1 kept after line0 read");
        wr(5, 8'hFF);
        chk({7'b0, irq1}, 8'h01, "R7 write ignored");
        rd_chk(5, 8'h80, "R7 line1 read returns");
        chk({7'b0, irq1}, 8'h00, "R7 irq1 dropped after read");
        // Hold-over on: second event kept
        wr(18, 8'h00);
        pulse(0); pulse(0);
        wr(0, 8'h01);
        rd_chk(0, 8'h01, "R9 held event re-asserts");
        wr(0, 8'h01);
        rd_chk(0, 8'h00, "R9 clear after held");
        // Hold-off: second event dropped
        wr(18, 8'h02);
        pulse(0); pulse(0);
        wr(0, 8'h01);
        rd_chk(0, 8'h00, "R9 hold-off drops second");
        // Sync latency on source 0
        src[0] = 1'b1;
        idle(1); idle(1);
        chk({7'b0, irq0}, 8'h00, "R1 not yet after two edges");
        idle(1);
        chk({7'b0, irq0}, 8'h01, "R1 request after third edge");
        src[0] = 1'b0; idle(4);
        wr(0, 8'h01);
        // Clear and event in same cycle on source 9
        src[9] = 1'b1; idle(5);
        src[9] = 1'b0;
        idle(2);
        wr(1, 8'h02);
        idle(2);
        rd_chk(1, 8'h02, "R10 event beats clear");
        wr(1, 8'h02);
        rd_chk(1, 8'h00, "R10 later clear works");
        rd_chk(19, 8'h00, "R11 unmapped reads zero");
        idle(3);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule